// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block sits between a kernel launcher and a row of compute clusters. Each launch request describes one thread block: how many threads it has, how many 32-bit registers each thread needs, and how many bytes of shared memory the block needs. The dispatcher checks the request against the per-block maxima. An illegal request is consumed and flagged. A legal one is placed on a cluster that has room for it on all five resource counters.

Clusters are tried round-robin, starting after the cluster that took the previous block. When no cluster has room, the request waits with ready low. Once a block is placed, it is cut into warps of 32 threads. One warp descriptor per cycle goes out to the chosen cluster, carrying the first thread ID and an active-lane mask. When a block finishes, the cluster reports its size on that cluster's completion inputs, and the dispatcher releases the block's resources.

Top module: `block_admitter`

## Requirements
- R1: A request with 0 threads, more than 1024 threads, more than 255 registers per thread, or more than 49152 shared bytes is accepted in the same cycle with `req_ready`=1 and `req_err`=1. It emits no warp descriptor and changes no cluster counter.
- R2: An admitted block of T threads produces exactly ceil(T/32) descriptors on consecutive cycles, starting the cycle after acceptance, all carrying the chosen cluster index on `wd_cluster`.
- R3: Descriptor i of a block has `wd_first_tid` = 32*i. `wd_last` is 1 only on the final descriptor.
- R4: `wd_mask` bit k is lane k. A full warp has all 32 bits set. A partial final warp of r threads has bits r-1..0 set and all other bits clear.
- R5: The search for a cluster starts at the cluster after the one that took the last admitted block. Rejected requests do not move that starting point.
- R6: A cluster that lacks room on any counter is skipped, and the next cluster in round-robin order that fits is chosen.
- R7: A cluster never holds more than 16 blocks, 64 warps, 2048 threads, 65536 registers (threads × registers per thread) or 49152 shared bytes. If no cluster fits, `req_ready` stays low and the request is held.
- R8: A pulse on `done_valid[c]`, carrying the block's thread count, registers per thread and shared bytes, frees that block's share of all five counters on cluster c. The freed room is usable from the next cycle.
- R9: While descriptors are being emitted, `req_ready` is low.
- R10: After reset no descriptor is emitted, all clusters are empty, and the first admitted block goes to cluster 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request consumed this cycle |
| req_err | output | 1 | Consumed request was illegal |
| req_threads | input | 11 | Threads in the block |
| req_regs | input | 9 | Registers per thread |
| req_smem | input | 17 | Shared memory bytes for the block |
| wd_valid | output | 1 | Warp descriptor valid |
| wd_cluster | output | 2 | Destination cluster |
| wd_first_tid | output | 11 | Thread ID of lane 0 |
| wd_mask | output | 32 | Active lanes |
| wd_last | output | 1 | Final warp of the block |
| done_valid | input | 4 | Per-cluster block completion pulse |
| done_threads | input | 44 | Per cluster, 11 bits: threads of finished block |
| done_regs | input | 36 | Per cluster, 9 bits: registers per thread |
| done_smem | input | 68 | Per cluster, 17 bits: shared bytes |

## Verification
Some properties are checked by assertions on every cycle. These are: the per-cluster counters stay within their limits, descriptors advance in steps of 32 thread IDs on the same cluster, every mask is a contiguous run from lane 0, admission is followed by a descriptor with ID 0, an error is followed by none, and ready is low while a block is being emitted. Other behaviour can only be shown by the bench's scenarios: the round-robin order, the skipping of full clusters, holding a request that fits nowhere, and release on completion. These depend on a sequence of several blocks and on what the caller expects.

// File: rtl/block_admitter.sv
module block_admitter #(
  parameter int NCL      = 4,
  parameter int MAX_BLK  = 16,
  parameter int MAX_WARP = 64,
  parameter int MAX_THR  = 2048,
  parameter int MAX_REG  = 65536,
  parameter int MAX_SMEM = 49152,
  parameter int BLK_THR  = 1024,
  parameter int THR_REG  = 255,
  localparam int TW = $clog2(BLK_THR + 1),
  localparam int RW = $clog2(THR_REG + 1) + 1,
  localparam int SW = $clog2(MAX_SMEM + 1) + 1,
  localparam int CW = (NCL > 1) ? $clog2(NCL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              req_err,
  input  logic [TW-1:0]     req_threads,
  input  logic [RW-1:0]     req_regs,
  input  logic [SW-1:0]     req_smem,
  output logic              wd_valid,
  output logic [CW-1:0]     wd_cluster,
  output logic [TW-1:0]     wd_first_tid,
  output logic [31:0]       wd_mask,
  output logic              wd_last,
  input  logic [NCL-1:0]    done_valid,
  input  logic [NCL*TW-1:0] done_threads,
  input  logic [NCL*RW-1:0] done_regs,
  input  logic [NCL*SW-1:0] done_smem
);
  localparam int WS = 32;

  logic [31:0] n_thr, n_reg, n_smem, n_wrp, n_rgs;
  logic bad, found, admit, busy;
  logic [NCL-1:0] fits;
  logic [CW-1:0] pick, last, cur_cl;
  logic [TW-1:0] tid, left;

  assign n_thr  = 32'(req_threads);
  assign n_reg  = 32'(req_regs);
  assign n_smem = 32'(req_smem);
  assign n_wrp  = (n_thr + WS - 1) / WS;
  assign n_rgs  = n_thr * n_reg;
  assign bad    = (n_thr == 0) || (n_thr > BLK_THR) || (n_reg > THR_REG) || (n_smem > MAX_SMEM);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NCL; k++) begin
      int idx;
      idx = (int'(last) + k) % NCL;
      if (!found && fits[idx]) begin
        found = 1'b1;
        pick  = CW'(idx);
      end
    end
  end

  assign req_ready = !busy && (bad || found);
  assign req_err   = !busy && req_valid && bad;
  assign admit     = req_valid && req_ready && !bad;

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    logic [31:0] blk, wrp, thr, rgs, smb;
    logic [31:0] d_thr, d_wrp, d_rgs, d_smb;
    logic add, dn;

    assign d_thr = 32'(done_threads[c*TW +: TW]);
    assign d_wrp = (d_thr + WS - 1) / WS;
    assign d_rgs = d_thr * 32'(done_regs[c*RW +: RW]);
    assign d_smb = 32'(done_smem[c*SW +: SW]);
    assign add   = admit && (pick == CW'(c));
    assign dn    = done_valid[c];

    assign fits[c] = (blk + 1 <= MAX_BLK) && (wrp + n_wrp <= MAX_WARP) &&
                     (thr + n_thr <= MAX_THR) && (rgs + n_rgs <= MAX_REG) &&
                     (smb + n_smem <= MAX_SMEM);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        blk <= '0; wrp <= '0; thr <= '0; rgs <= '0; smb <= '0;
      end else begin
        blk <= blk + (add ? 32'd1 : 32'd0) - (dn ? 32'd1 : 32'd0);
        wrp <= wrp + (add ? n_wrp : 32'd0) - (dn ? d_wrp : 32'd0);
        thr <= thr + (add ? n_thr : 32'd0) - (dn ? d_thr : 32'd0);
        rgs <= rgs + (add ? n_rgs : 32'd0) - (dn ? d_rgs : 32'd0);
        smb <= smb + (add ? n_smem : 32'd0) - (dn ? d_smb : 32'd0);
      end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      blk <= MAX_BLK && wrp <= MAX_WARP && thr <= MAX_THR && rgs <= MAX_REG && smb <= MAX_SMEM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cur_cl <= '0; last <= CW'(NCL - 1); tid <= '0; left <= '0;
    end else if (admit) begin
      busy <= 1'b1; cur_cl <= pick; last <= pick; tid <= '0; left <= req_threads;
    end else if (busy) begin
      if (left <= TW'(WS)) busy <= 1'b0;
      tid  <= tid + TW'(WS);
      left <= left - TW'(WS);
    end
  end

  assign wd_valid     = busy;
  assign wd_cluster   = cur_cl;
  assign wd_first_tid = tid;
  assign wd_last      = busy && (left <= TW'(WS));
  assign wd_mask      = !busy ? 32'd0 : (left >= TW'(WS)) ? '1 : ((32'd1 << left) - 32'd1);

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> !req_ready);
  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_err) |=> (wd_valid && wd_first_tid == '0));
  p_err_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !wd_valid);
  p_tid_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_last) |=> (wd_valid && wd_first_tid == $past(wd_first_tid) + TW'(WS) &&
                                wd_cluster == $past(wd_cluster)));
  p_mask_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> (wd_mask[0] && ((wd_mask & (wd_mask + 32'd1)) == 32'd0)));
endmodule

// File: tb/sim_block_admitter.sv
module sim_block_admitter;
  localparam int NCL = 4, TW = 11, RW = 9, SW = 17;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_err;
  logic [TW-1:0] req_threads = '0;
  logic [RW-1:0] req_regs = '0;
  logic [SW-1:0] req_smem = '0;
  logic wd_valid, wd_last;
  logic [1:0] wd_cluster;
  logic [TW-1:0] wd_first_tid;
  logic [31:0] wd_mask;
  logic [NCL-1:0] done_valid = '0;
  logic [NCL*TW-1:0] done_threads = '0;
  logic [NCL*RW-1:0] done_regs = '0;
  logic [NCL*SW-1:0] done_smem = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  block_admitter u0 (.*);

  // threads, regs, smem, expect_err, expect_cluster
  localparam int NV = 11;
  localparam int V_THR[NV] = '{64, 33, 2000, 32, 16, 0, 1024, 100, 1, 32, 32};
  localparam int V_REG[NV] = '{10, 8, 4, 256, 1, 1, 64, 1, 1, 1, 1};
  localparam int V_SM [NV] = '{0, 100, 0, 0, 49153, 0, 0, 49152, 0, 0, 1};
  localparam int V_ERR[NV] = '{0, 0, 1, 1, 1, 1, 0, 0, 0, 0, 0};
  localparam int V_CL [NV] = '{0, 1, 0, 0, 0, 0, 2, 3, 0, 1, 0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mask(input int rem);
    return (rem >= 32) ? 32'hFFFF_FFFF : ((32'd1 << rem) - 32'd1);
  endfunction

  task automatic collect(input int thr, input int cl);
    int nw = (thr + 31) / 32;
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      chk(wd_valid == 1, "R2 valid", 32'(wd_valid), 1);
      chk(wd_cluster == 2'(cl), "R2/R5/R6 cluster", 32'(wd_cluster), 32'(cl));
      chk(wd_first_tid == TW'(32 * i), "R3 tid", 32'(wd_first_tid), 32'(32 * i));
      chk(wd_mask == exp_mask(thr - 32 * i), "R4 mask", wd_mask, exp_mask(thr - 32 * i));
      chk(wd_last == (i == nw - 1), "R3 last", 32'(wd_last), 32'(i == nw - 1));
      chk(req_ready == 0, "R9 ready low", 32'(req_ready), 0);
    end
    @(negedge clk);
    chk(wd_valid == 0, "R2 count", 32'(wd_valid), 0);
  endtask

  task automatic send(input int thr, input int rg, input int sm, input int e, input int cl);
    int guard = 0;
    @(negedge clk);
    req_threads = TW'(thr); req_regs = RW'(rg); req_smem = SW'(sm); req_valid = 1;
    #1;
    while (!req_ready && guard < 50) begin @(negedge clk); #1; guard++; end
    chk(req_err == 1'(e), "R1 err flag", 32'(req_err), 32'(e));
    @(posedge clk); #1 req_valid = 0;
    if (e != 0) begin
      @(negedge clk);
      chk(wd_valid == 0, "R1 no descriptor", 32'(wd_valid), 0);
    end else collect(thr, cl);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wd_valid == 0, "R10 no descriptor in reset", 32'(wd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(wd_valid == 0, "R10 idle after reset", 32'(wd_valid), 0);
    chk(req_err == 0, "R10 no error", 32'(req_err), 0);

    for (int v = 0; v < NV; v++) send(V_THR[v], V_REG[v], V_SM[v], V_ERR[v], V_CL[v]);

    // R7: a block needing 65536 registers fits nowhere and is held
    @(negedge clk);
    req_threads = 11'd1024; req_regs = 9'd64; req_smem = '0; req_valid = 1;
    for (int i = 0; i < 4; i++) begin
      #1 chk(req_ready == 0, "R7 held", 32'(req_ready), 0);
      @(negedge clk);
    end
    // R8: cluster 3 finishes its 100-thread block
    done_valid[3] = 1;
    done_threads[3*TW +: TW] = 11'd100;
    done_regs[3*RW +: RW] = 9'd1;
    done_smem[3*SW +: SW] = 17'd49152;
    #1 chk(req_ready == 0, "R8 not yet freed", 32'(req_ready), 0);
    @(posedge clk); #1 done_valid = '0;
    @(negedge clk); #1;
    chk(req_ready == 1, "R8 freed room", 32'(req_ready), 1);
    chk(req_err == 0, "R8 no error", 32'(req_err), 0);
    @(posedge clk); #1 req_valid = 0;
    collect(1024, 3);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule